// File: doc/BRIEF.md
# Per-Locality Interrupt Controller

This block holds an interrupt-enable word and an interrupt-status word for each locality of a multi-locality command interface. It drives one interrupt line that all localities share. Four event types are tracked: response data available, status valid, locality changed and ready for a command. An event arrives as a one-cycle strobe tagged with a locality. It is recorded in that locality's status word only when that locality has turned on both its global enable and the enable bit for that event. Software clears status bits by writing ones to them. The line drops when a clear empties the status word of the locality being written.

The register port is a plain single-cycle control port. A write takes effect at the clock edge on which `reg_wr` is high. A read returns data combinationally from `reg_loc` and `reg_sel`. The port has no stream data, so it has no back-pressure and no valid/ready pair.

The block also returns a fixed capability word and a vector register that holds the configured interrupt number. It stores the polarity field of the enable word but does not act on it.

Top module: `loc_irq_ctrl`

## Requirements
- R1: After reset, every locality's enable word reads 0x00000008 (polarity field bits 4:3 = 01), every status word reads 0 and `irq` is 0.
- R2: A write to the enable word (`reg_sel` = 0) keeps only these bits: bit 31 (global enable), bits 4:3 (polarity), bit 0 (data available), bit 1 (status valid), bit 2 (locality changed) and bit 7 (command ready). It stores `reg_wdata & 0x8000009F`.
- R3: An event strobe (`evt_kind` bit 0 = data available, bit 1 = status valid, bit 2 = locality changed, bit 3 = command ready) sets status bits 0, 1, 2 and 7 respectively. A bit is set only if the target locality has bit 31 and that event's own enable bit set.
- R4: `irq` is high in the cycle after an event strobe that sets at least one status bit.
- R5: A write to the status word (`reg_sel` = 1) clears every status bit written as 1 and leaves the other bits unchanged.
- R6: `irq` goes low in the cycle after a status write that clears at least one set bit and leaves that locality's status at zero. In the same cycle no event may set a bit. Otherwise `irq` keeps its value.
- R7: A write to the enable or status word is ignored unless `reg_loc` equals `active_loc` and `active_loc` is below NUM_LOC. A value of NUM_LOC or more means no locality is active.
- R8: The vector register (`reg_sel` = 2) reads IRQ_VEC (0 to 15) in bits 3:0 and zero above. Writes to it have no effect.
- R9: The capability word (`reg_sel` = 3) reads 0x20000697. Writes to it have no effect.
- R10: An event strobe whose `evt_loc` is NUM_LOC or more changes no state and does not raise `irq`.
- R11: No status bit outside bits 0, 1, 2 and 7 is ever set. A read of the enable or status word for a `reg_loc` of NUM_LOC or more returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| active_loc | input | LOC_W | Index of the active locality; NUM_LOC or more means none |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_sel | input | 2 | Register select: 0 enable, 1 status, 2 vector, 3 capability |
| reg_loc | input | LOC_W | Locality that the access targets |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_loc/reg_sel |
| evt_valid | input | 1 | Event strobe |
| evt_loc | input | LOC_W | Locality tag of the event |
| evt_kind | input | 4 | Event types present in this strobe |
| irq | output | 1 | Shared interrupt line, active high |

## Verification
Enable and status words change at the clock edge that samples a write or an event. `irq` is registered and changes at that same edge, so every result is due one edge after its stimulus. `reg_rdata` is combinational and follows `reg_loc` and `reg_sel` without delay.

The bench drives inputs after a falling edge and updates its own model at the rising edge. At the next falling edge it sweeps every locality's enable and status words through the read port in short steps, then compares them and `irq` with the model, all before the following rising edge.

// File: rtl/loc_irq_pkg.sv
package loc_irq_pkg;
  localparam logic [31:0] EN_WMASK   = 32'h8000_009F;
  localparam logic [31:0] EVT_BITS   = 32'h0000_0087;
  localparam logic [31:0] EN_RESET   = 32'h0000_0008;
  localparam logic [31:0] CAP_WORD   = (32'd2 << 28) | (32'd3 << 9) | (32'd1 << 4) | EVT_BITS;
  localparam int          GIE_BIT    = 31;

  typedef enum logic [1:0] {
    SEL_EN  = 2'd0,
    SEL_ST  = 2'd1,
    SEL_VEC = 2'd2,
    SEL_CAP = 2'd3
  } reg_sel_e;

  function automatic logic [31:0] kind_to_bits(input logic [3:0] k);
    logic [31:0] b;
    b = '0;
    b[0] = k[0];
    b[1] = k[1];
    b[2] = k[2];
    b[7] = k[3];
    return b;
  endfunction
endpackage

// File: rtl/loc_irq_bank.sv
module loc_irq_bank
  import loc_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en_wr,
  input  logic        st_clr_wr,
  input  logic [31:0] wdata,
  input  logic [3:0]  evt_kind,
  output logic [31:0] en_q,
  output logic [31:0] st_q,
  output logic        set_fire,
  output logic        clr_empty
);
  logic [31:0] set_bits, clr_bits, st_next;

  always_comb begin
    set_bits  = en_q[GIE_BIT] ? (kind_to_bits(evt_kind) & en_q & EVT_BITS) : '0;
    clr_bits  = st_clr_wr ? (wdata & EVT_BITS) : '0;
    st_next   = (st_q & ~clr_bits) | set_bits;
    set_fire  = |set_bits;
    clr_empty = (|(st_q & clr_bits)) && (st_next == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= EN_RESET;
      st_q <= '0;
    end else begin
      if (en_wr) en_q <= wdata & EN_WMASK;
      st_q <= st_next;
    end
  end

  // R2: enable word never holds an unsupported bit
  p_en_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q & ~EN_WMASK) == '0);
  // R11: status holds only event bits
  p_st_bits_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q & ~EVT_BITS) == '0);
  // R3: without the global enable, events leave status alone
  p_gie_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_kind != '0 && !en_q[GIE_BIT] && !st_clr_wr) |=> $stable(st_q));
  // R7: enable changes only through a decoded write
  p_en_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr |=> $stable(en_q));
endmodule

// File: rtl/loc_irq_line.sv
module loc_irq_line #(
  parameter int NUM_LOC = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_LOC-1:0] set_fire,
  input  logic [NUM_LOC-1:0] clr_empty,
  output logic               irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           irq <= 1'b0;
    else if (|set_fire)   irq <= 1'b1;
    else if (|clr_empty)  irq <= 1'b0;
  end

  // R4: a latched event raises the line on the next edge
  p_irq_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_fire) |=> irq);
  // R6: the line only falls after a clear that emptied a status word
  p_irq_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(|clr_empty));
endmodule

// File: rtl/loc_irq_ctrl.sv
module loc_irq_ctrl
  import loc_irq_pkg::*;
#(
  parameter int NUM_LOC = 5,
  parameter int IRQ_VEC = 5,
  localparam int LOC_W  = (NUM_LOC > 1) ? $clog2(NUM_LOC + 1) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LOC_W-1:0] active_loc,
  input  logic             reg_wr,
  input  logic [1:0]       reg_sel,
  input  logic [LOC_W-1:0] reg_loc,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             evt_valid,
  input  logic [LOC_W-1:0] evt_loc,
  input  logic [3:0]       evt_kind,
  output logic             irq
);
  localparam logic [31:0] VEC_WORD = {28'd0, 4'(IRQ_VEC)};

  logic [31:0]        en_q [NUM_LOC];
  logic [31:0]        st_q [NUM_LOC];
  logic [NUM_LOC-1:0] set_fire, clr_empty;
  logic               act_valid, wr_ok;

  assign act_valid = 32'(active_loc) < NUM_LOC;
  assign wr_ok     = reg_wr && act_valid && (reg_loc == active_loc);

  for (genvar i = 0; i < NUM_LOC; i++) begin : g_loc
    logic hit;
    assign hit = wr_ok && (32'(reg_loc) == i);
    loc_irq_bank u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_wr     (hit && reg_sel == SEL_EN),
      .st_clr_wr (hit && reg_sel == SEL_ST),
      .wdata     (reg_wdata),
      .evt_kind  ((evt_valid && 32'(evt_loc) == i) ? evt_kind : 4'd0),
      .en_q      (en_q[i]),
      .st_q      (st_q[i]),
      .set_fire  (set_fire[i]),
      .clr_empty (clr_empty[i])
    );
  end

  loc_irq_line #(.NUM_LOC(NUM_LOC)) u_line (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_fire  (set_fire),
    .clr_empty (clr_empty),
    .irq       (irq)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      SEL_VEC: reg_rdata = VEC_WORD;
      SEL_CAP: reg_rdata = CAP_WORD;
      default: begin
        for (int i = 0; i < NUM_LOC; i++) begin
          if (32'(reg_loc) == i)
            reg_rdata = (reg_sel == SEL_EN) ? en_q[i] : st_q[i];
        end
      end
    endcase
  end

  // R10: an event for no valid locality cannot raise the line
  p_bad_loc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && 32'(evt_loc) >= NUM_LOC && !irq && !wr_ok) |=> !irq);
  // R9: capability word is fixed
  p_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == SEL_CAP) |-> reg_rdata == 32'h2000_0697);
endmodule

// File: tb/sim_loc_irq_ctrl.sv
`timescale 1ns/1ps
module sim_loc_irq_ctrl;
  localparam int NL = 5;
  localparam int LW = 3;
  localparam int VEC = 5;

  logic clk = 0, rst_n = 0;
  logic [LW-1:0] active_loc = 0, reg_loc = 0, evt_loc = 0;
  logic reg_wr = 0, evt_valid = 0;
  logic [1:0] reg_sel = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [3:0] evt_kind = 0;
  logic irq;

  int n_tests = 0, n_fail = 0, cycles = 0;
  logic [31:0] m_en [NL];
  logic [31:0] m_st [NL];
  logic m_irq;

  always #5 clk = ~clk;

  loc_irq_ctrl #(.NUM_LOC(NL), .IRQ_VEC(VEC)) u0 (
    .clk, .rst_n, .active_loc, .reg_wr, .reg_sel, .reg_loc, .reg_wdata,
    .reg_rdata, .evt_valid, .evt_loc, .evt_kind, .irq);

  function automatic logic [31:0] kbits(logic [3:0] k);
    return {24'd0, k[3], 4'd0, k[2], k[1], k[0]};
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NL; i++) begin m_en[i] = 32'h8; m_st[i] = 0; end
    m_irq = 0;
  endtask

  task automatic model_step();
    logic any_set, any_drop, wok;
    logic [31:0] clr, set, nxt;
    any_set = 0; any_drop = 0;
    wok = reg_wr && active_loc < NL && reg_loc == active_loc;
    for (int i = 0; i < NL; i++) begin
      clr = (wok && reg_sel == 1 && reg_loc == i) ? (reg_wdata & 32'h87) : 0;
      set = (evt_valid && evt_loc == i && m_en[i][31]) ? (kbits(evt_kind) & m_en[i] & 32'h87) : 0;
      nxt = (m_st[i] & ~clr) | set;
      if (set != 0) any_set = 1;
      if ((m_st[i] & clr) != 0 && nxt == 0) any_drop = 1;
      m_st[i] = nxt;
      if (wok && reg_sel == 0 && reg_loc == i) m_en[i] = reg_wdata & 32'h8000009F;
    end
    if (any_set) m_irq = 1;
    else if (any_drop) m_irq = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    reg_wr = 0; evt_valid = 0;
  endtask

  task automatic check_all(string req);
    for (int i = 0; i < NL; i++) begin
      reg_loc = LW'(i); reg_sel = 0; #0.2;
      chk({req, " enable"}, reg_rdata, m_en[i]);
      reg_sel = 1; #0.2;
      chk({req, " status"}, reg_rdata, m_st[i]);
    end
    chk({req, " irq"}, {31'd0, irq}, {31'd0, m_irq});
  endtask

  task automatic wr(int loc, int sel, logic [31:0] d);
    reg_wr = 1; reg_loc = LW'(loc); reg_sel = 2'(sel); reg_wdata = d;
  endtask

  task automatic ev(int loc, logic [3:0] k);
    evt_valid = 1; evt_loc = LW'(loc); evt_kind = k;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd1234));
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R1");

    active_loc = 1;
    wr(1, 0, 32'hFFFF_FFFF); tick();
    check_all("R2");
    wr(1, 0, 32'h0000_0087); tick();
    ev(1, 4'hF); tick();
    check_all("R3 no global enable");
    wr(1, 0, 32'h8000_0005); tick();
    ev(1, 4'hF); tick();
    check_all("R3 partial enable");
    check_all("R4");
    wr(1, 1, 32'h0000_0001); tick();
    check_all("R5 partial clear");
    check_all("R6 stays high");
    active_loc = 2;
    wr(1, 1, 32'hFFFF_FFFF); tick();
    check_all("R7 inactive status write");
    wr(1, 0, 32'h0); tick();
    check_all("R7 inactive enable write");
    active_loc = 7;
    wr(1, 1, 32'hFFFF_FFFF); tick();
    check_all("R7 no active locality");
    active_loc = 1;
    wr(1, 1, 32'h0000_0004); tick();
    check_all("R6 drop");
    wr(1, 2, 32'h0000_000A); tick();
    reg_sel = 2; #0.2; chk("R8 vector", reg_rdata, VEC);
    wr(1, 3, 32'h0); tick();
    reg_sel = 3; #0.2; chk("R9 capability", reg_rdata, 32'h2000_0697);
    ev(5, 4'hF); tick();
    ev(7, 4'hF); tick();
    check_all("R10");
    reg_loc = 6; reg_sel = 0; #0.2; chk("R11 invalid loc read", reg_rdata, 0);

    for (int n = 0; n < 600; n++) begin
      active_loc = LW'($urandom_range(0, 6));
      if ($urandom_range(0, 2) != 0) begin
        r = $urandom;
        if ($urandom_range(0, 1) == 1) r[31] = 1'b1;
        if ($urandom_range(0, 2) == 0) wr(active_loc, $urandom_range(0, 3), r);
        else wr($urandom_range(0, 6), $urandom_range(0, 3), r);
      end
      if ($urandom_range(0, 1) == 1) ev($urandom_range(0, 6), 4'($urandom));
      tick();
      check_all("R3 R5 R6 R11 random");
    end
    finish_run();
  end
endmodule